// File: doc/BRIEF.md
# Test-Mode Unlock Key Register

This block is a 32-bit software-visible control register that opens two separate test modes: a firmware test mode and a secure test mode. Neither key can be written as a whole word. Software builds each 32-bit key one byte at a time. It first places a data byte in the register. It then raises and lowers the latch-enable bit for the byte position it wants to fill. When the enable drops, the held data byte is copied into that key byte.

Each assembled key is compared against a magic constant set by a parameter. A matching key raises a read-only OK flag one cycle later. While the secure key matches, an output that denies access to protected storage regions is held high.

The two keys live in different reset domains. The firmware key, the control fields and the lockout bit are cleared by the normal reset. The secure key and its OK flag survive a normal reset and are cleared only by the power-on reset. A write-1-to-set lockout bit stops all further secure-key byte capture until the next reset.

Top module: `testKeyUnlock`

## Requirements
- R1: After power-on reset every readable bit is 0, and fwKeyOk, secKeyOk and secAccessBlock are 0.
- R2: Readback layout: data byte in bits [7:0], firmware byte enables in [11:8], secure byte enables in [19:16], firmware OK in bit 29, secure OK in bit 30, lockout in bit 31. Every other bit reads 0, even when written with 1.
- R3: A key byte n is captured only when its enable bit goes from 1 to 0 in a write that keeps the data byte unchanged. Raising an enable captures nothing.
- R4: An OK flag is 1 exactly when all four stored bytes of its key equal the magic value, and it appears one clock after the last byte is stored. Overwriting any byte with a wrong value clears the flag one clock later.
- R5: Writing 1 to bit 31 sets the lockout. Writing 0 to bit 31 never clears it; only a reset does.
- R6: A write that changes the data byte captures no key byte, even when enable bits fall in the same write.
- R7: While the lockout is set, the secure key is never modified.
- R8: A write that sets bit 31 is ignored as a whole (no field changes) if any secure enable bit is currently 1 or is 1 in the written value.
- R9: The normal reset clears the firmware key, its OK flag, the control fields and the lockout, and leaves the secure key and its OK flag intact. The power-on reset clears everything.
- R10: secAccessBlock is 1 whenever the secure OK flag is 1, and 0 otherwise.
- R11: Bits 29 and 30 are read-only: writing them has no effect on the flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Normal reset, active low, asynchronous |
| porRstN | input | 1 | Power-on reset, active low, asynchronous; also resets the normal domain |
| wrEn | input | 1 | Register write strobe |
| wrData | input | 32 | Register write value |
| rdData | output | 32 | Register read value |
| fwKeyOk | output | 1 | Firmware test key matches |
| secKeyOk | output | 1 | Secure test key matches |
| secAccessBlock | output | 1 | Deny access to secure storage regions |

## Verification
A wrong stored key byte is hidden inside the block and cannot be read directly. It shows at the ports only through the OK flags, one clock after the write that stored it. For that reason the tests bring each key to exactly one mismatching byte and then watch the flag. This makes the effect of a missed or stray capture visible on the next cycle.

Faults in the reset domains show up right after a reset pulse. The firmware flag must drop while the secure flag and the access block stay high. A broken lockout or a faulty conflict-ignore rule appears in the readback of bits 31 and [19:16] immediately after the offending write. It also shows later as a secure flag that changes when it should not.

// File: rtl/tkuPkg.sv
package tkuPkg;
  localparam int BYTE_W     = 8;
  localparam int KEY_BYTES  = 4;
  localparam int KEY_W      = BYTE_W * KEY_BYTES;
  localparam int REG_W      = 32;
  localparam int DATA_LSB   = 0;
  localparam int FW_WR_LSB  = 8;
  localparam int SEC_WR_LSB = 16;
  localparam int FW_OK_BIT  = 29;
  localparam int SEC_OK_BIT = 30;
  localparam int SEC_DIS_BIT = 31;

  typedef struct packed {
    logic [KEY_BYTES-1:0] fwLoad;
    logic [KEY_BYTES-1:0] secLoad;
    logic [BYTE_W-1:0]    loadByte;
  } keyStrobes_t;
endpackage

// File: rtl/tkuCtrl.sv
module tkuCtrl
  import tkuPkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  wrEn,
  input  logic [REG_W-1:0]      wrData,
  output logic [BYTE_W-1:0]     dataByte,
  output logic [KEY_BYTES-1:0]  fwWr,
  output logic [KEY_BYTES-1:0]  secWr,
  output logic                  secDisable,
  output keyStrobes_t           strobes
);
  logic [BYTE_W-1:0]    newData;
  logic [KEY_BYTES-1:0] newFw;
  logic [KEY_BYTES-1:0] newSec;
  logic                 setDis;
  logic                 disConflict;
  logic                 acceptWr;
  logic                 dataHeld;

  always_comb begin
    newData     = wrData[DATA_LSB +: BYTE_W];
    newFw       = wrData[FW_WR_LSB +: KEY_BYTES];
    newSec      = wrData[SEC_WR_LSB +: KEY_BYTES];
    setDis      = wrData[SEC_DIS_BIT];
    disConflict = setDis && ((secWr != '0) || (newSec != '0));
    acceptWr    = wrEn && !disConflict;
    dataHeld    = (newData == dataByte);
    strobes.loadByte = dataByte;
    strobes.fwLoad   = (acceptWr && dataHeld) ? (fwWr & ~newFw) : '0;
    strobes.secLoad  = (acceptWr && dataHeld && !secDisable) ? (secWr & ~newSec) : '0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dataByte   <= '0;
      fwWr       <= '0;
      secWr      <= '0;
      secDisable <= 1'b0;
    end else if (acceptWr) begin
      dataByte   <= newData;
      fwWr       <= newFw;
      secWr      <= newSec;
      secDisable <= secDisable | setDis;
    end
  end

  // R5: lockout cannot be cleared by a write
  a_r5_lock_sticky: assert property (@(posedge clk) disable iff (!rstN)
    secDisable |=> secDisable);

  // R6: changed data byte means no capture
  a_r6_no_load_on_data_change: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && (wrData[DATA_LSB +: BYTE_W] != dataByte)) |->
      (strobes.fwLoad == '0 && strobes.secLoad == '0));

  // R7: no secure strobes while locked
  a_r7_locked_no_sec_load: assert property (@(posedge clk) disable iff (!rstN)
    secDisable |-> (strobes.secLoad == '0));

  // R8: conflicting lockout write leaves fields untouched
  a_r8_conflict_ignored: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrData[SEC_DIS_BIT] && (wrData[SEC_WR_LSB +: KEY_BYTES] != '0)) |=>
      ($stable(secDisable) && $stable(dataByte) && $stable(secWr) && $stable(fwWr)));
endmodule

// File: rtl/tkuKeyBank.sv
module tkuKeyBank
  import tkuPkg::*;
#(
  parameter logic [KEY_W-1:0] MAGIC = '0
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [KEY_BYTES-1:0] load,
  input  logic [BYTE_W-1:0]    loadByte,
  output logic                 keyOk
);
  logic [KEY_W-1:0] keyQ;
  logic             match;

  for (genvar b = 0; b < KEY_BYTES; b++) begin : g_byte
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)        keyQ[b*BYTE_W +: BYTE_W] <= '0;
      else if (load[b]) keyQ[b*BYTE_W +: BYTE_W] <= loadByte;
    end
  end

  assign match = (keyQ == MAGIC);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) keyOk <= 1'b0;
    else       keyOk <= match;
  end

  // R3: key bytes change only under a load strobe
  a_r3_hold_without_load: assert property (@(posedge clk) disable iff (!rstN)
    (load == '0) |=> $stable(keyQ));

  // R4: flag only rises after a full match
  a_r4_rise_needs_match: assert property (@(posedge clk) disable iff (!rstN)
    $rose(keyOk) |-> $past(keyQ == MAGIC));
endmodule

// File: rtl/tkuDatapath.sv
module tkuDatapath
  import tkuPkg::*;
#(
  parameter logic [KEY_W-1:0] FW_MAGIC  = 32'hC3A5_5A3C,
  parameter logic [KEY_W-1:0] SEC_MAGIC = 32'h7E19_B2D4
) (
  input  logic        clk,
  input  logic        normRstN,
  input  logic        porRstN,
  input  keyStrobes_t strobes,
  output logic        fwOk,
  output logic        secOk,
  output logic        secBlock
);
  tkuKeyBank #(.MAGIC(FW_MAGIC)) fwBank_i (
    .clk(clk), .rstN(normRstN), .load(strobes.fwLoad),
    .loadByte(strobes.loadByte), .keyOk(fwOk));

  tkuKeyBank #(.MAGIC(SEC_MAGIC)) secBank_i (
    .clk(clk), .rstN(porRstN), .load(strobes.secLoad),
    .loadByte(strobes.loadByte), .keyOk(secOk));

  assign secBlock = secOk;
endmodule

// File: rtl/testKeyUnlock.sv
module testKeyUnlock
  import tkuPkg::*;
#(
  parameter logic [31:0] FW_MAGIC  = 32'hC3A5_5A3C,
  parameter logic [31:0] SEC_MAGIC = 32'h7E19_B2D4
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        porRstN,
  input  logic        wrEn,
  input  logic [31:0] wrData,
  output logic [31:0] rdData,
  output logic        fwKeyOk,
  output logic        secKeyOk,
  output logic        secAccessBlock
);
  logic                 normRstN;
  logic [BYTE_W-1:0]    dataByte;
  logic [KEY_BYTES-1:0] fwWr;
  logic [KEY_BYTES-1:0] secWr;
  logic                 secDisable;
  keyStrobes_t          strobes;

  assign normRstN = rstN & porRstN;

  tkuCtrl ctrl_i (
    .clk(clk), .rstN(normRstN), .wrEn(wrEn), .wrData(wrData),
    .dataByte(dataByte), .fwWr(fwWr), .secWr(secWr),
    .secDisable(secDisable), .strobes(strobes));

  tkuDatapath #(.FW_MAGIC(FW_MAGIC), .SEC_MAGIC(SEC_MAGIC)) dp_i (
    .clk(clk), .normRstN(normRstN), .porRstN(porRstN), .strobes(strobes),
    .fwOk(fwKeyOk), .secOk(secKeyOk), .secBlock(secAccessBlock));

  always_comb begin
    rdData = '0;
    rdData[DATA_LSB +: BYTE_W]      = dataByte;
    rdData[FW_WR_LSB +: KEY_BYTES]  = fwWr;
    rdData[SEC_WR_LSB +: KEY_BYTES] = secWr;
    rdData[FW_OK_BIT]               = fwKeyOk;
    rdData[SEC_OK_BIT]              = secKeyOk;
    rdData[SEC_DIS_BIT]             = secDisable;
  end

  // R10: block output tracks secure flag
  a_r10_block_tracks_ok: assert property (@(posedge clk) disable iff (!porRstN)
    secKeyOk |-> secAccessBlock);
endmodule

// File: tb/testKeyUnlock_tb_top.sv
module testKeyUnlock_tb_top;
  localparam logic [31:0] FWM  = 32'hC3A5_5A3C;
  localparam logic [31:0] SECM = 32'h7E19_B2D4;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        porRstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic        fwKeyOk, secKeyOk, secAccessBlock;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  testKeyUnlock #(.FW_MAGIC(FWM), .SEC_MAGIC(SECM)) dut_i (
    .clk(clk), .rstN(rstN), .porRstN(porRstN), .wrEn(wrEn), .wrData(wrData),
    .rdData(rdData), .fwKeyOk(fwKeyOk), .secKeyOk(secKeyOk),
    .secAccessBlock(secAccessBlock));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [31:0] v);
    @(negedge clk); wrEn = 1'b1; wrData = v;
    @(negedge clk); wrEn = 1'b0; wrData = '0;
  endtask

  // store one byte: raise enable then drop it with data held
  task automatic putByte(input bit sec, input int idx, input logic [7:0] val);
    int pos = sec ? 16 + idx : 8 + idx;
    wr((32'h1 << pos) | {24'h0, val});
    wr({24'h0, val});
    @(negedge clk);
  endtask

  task automatic tReset();
    repeat (3) @(negedge clk);
    porRstN = 1'b1; rstN = 1'b1;
    @(negedge clk);
    chk("R1 rdData", rdData, 32'h0);
    chk("R1 outputs", {29'h0, fwKeyOk, secKeyOk, secAccessBlock}, 32'h0);
  endtask

  task automatic tLayout();
    wr(32'h1FFA_FB5C);
    chk("R2 readback", rdData, 32'h000A_0B5C);
    wr(32'h0);  // data changes as enables fall: nothing captured
    chk("R6 flags after changed-data fall", {30'h0, fwKeyOk, secKeyOk}, 32'h0);
    wr(32'h6000_0000);
    chk("R11 ok bits read-only", rdData, 32'h0);
  endtask

  task automatic tFwKey();
    for (int i = 0; i < 3; i++) putByte(0, i, FWM[i*8 +: 8]);
    wr(32'h0000_0800 | {24'h0, FWM[31:24]});
    @(negedge clk);
    chk("R3 rising enable captures nothing", {31'h0, fwKeyOk}, 32'h0);
    wr({24'h0, FWM[31:24]});
    chk("R4 not yet one cycle", {31'h0, fwKeyOk}, 32'h0);
    @(negedge clk);
    chk("R4 fw ok", {31'h0, fwKeyOk}, 32'h1);
    chk("R2 fw ok bit", rdData, {2'b00, 1'b1, 21'h0, FWM[31:24]});
    chk("R10 no block from fw key", {31'h0, secAccessBlock}, 32'h0);
    putByte(0, 0, 8'h00);
    chk("R4 mismatch clears", {31'h0, fwKeyOk}, 32'h0);
    putByte(0, 0, FWM[7:0]);
    chk("R4 restored", {31'h0, fwKeyOk}, 32'h1);
    wr(32'h0000_0100 | 32'h11);
    wr({24'h0, FWM[7:0]});
    @(negedge clk);
    chk("R6 no capture on data change", {31'h0, fwKeyOk}, 32'h1);
  endtask

  task automatic tSecKey();
    for (int i = 0; i < 4; i++) putByte(1, i, SECM[i*8 +: 8]);
    chk("R4 sec ok", {31'h0, secKeyOk}, 32'h1);
    chk("R10 block set", {31'h0, secAccessBlock}, 32'h1);
    wr(32'h0001_0000 | {24'h0, SECM[7:0]});
    wr(32'h8000_0000 | 32'h42);
    chk("R8 conflicting write ignored", rdData,
        32'h6001_0000 | {24'h0, SECM[7:0]});
    wr({24'h0, SECM[7:0]});
    wr(32'h8000_0000);
    chk("R5 lockout set", {31'h0, rdData[31]}, 32'h1);
    wr(32'h0000_0033);
    chk("R5 lockout not cleared by write", {31'h0, rdData[31]}, 32'h1);
    putByte(1, 1, 8'h00);
    @(negedge clk);
    chk("R7 locked secure key unchanged", {31'h0, secKeyOk}, 32'h1);
  endtask

  task automatic tResets();
    @(negedge clk); rstN = 1'b0;
    @(negedge clk); rstN = 1'b1;
    repeat (2) @(negedge clk);
    chk("R9 fw flag cleared", {31'h0, fwKeyOk}, 32'h0);
    chk("R9 lockout cleared", {31'h0, rdData[31]}, 32'h0);
    chk("R9 secure kept", {30'h0, secKeyOk, secAccessBlock}, 32'h3);
    @(negedge clk); porRstN = 1'b0;
    @(negedge clk); porRstN = 1'b1;
    repeat (2) @(negedge clk);
    chk("R9 por clears secure", {30'h0, secKeyOk, secAccessBlock}, 32'h0);
    chk("R10 block off", {31'h0, secAccessBlock}, {31'h0, secKeyOk});
  endtask

  initial begin
    fork
      begin
        tReset(); tLayout(); tFwKey(); tSecKey(); tResets();
      end
      begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule